// File: doc/BRIEF.md
# Buffered Input Capture Bank

The block timestamps qualified edge events from a row of channels. When a channel reports an edge, the block writes the current value of the free-running main timer into that channel's capture register. Each channel also has a holding register, so software can read two timestamps. The first few channels also count their edges in 8-bit saturating pulse accumulators. Each accumulator has its own holding register.

A single mode input decides how the holding registers are loaded:

- **Queue mode:** every capture pushes the previous capture value into the channel's holding register. This gives a two-deep history per channel.
- **Latch mode:** captures only touch the capture registers. A latch event then snapshots all channels and all accumulators at once, and clears the accumulators. A latch event is the modulus down-counter reaching zero, or software writing zero to that counter.

Edge qualification, pin synchronisation, the modulus counter and interrupt flags are all outside the block.

Top module: `capt_hold_bank`

## Requirements
- R1: `latch_mode` = 0 selects queue mode and `latch_mode` = 1 selects latch mode. The mode in force in a cycle governs the update made at the end of that cycle.
- R2: In either mode, an edge on channel i in a cycle makes `cap_val[i*TW +: TW]` equal the `timer_val` of that cycle from the next clock edge on.
- R3: In queue mode, an edge on channel i moves the old capture value of that channel into `hold_val[i*TW +: TW]` at the same clock edge that loads the new capture value.
- R4: A latch event occurs in a cycle only when `latch_mode` = 1 and at least one of `mod_zero` or `mod_zero_wr` is 1. In queue mode, `mod_zero` and `mod_zero_wr` change no output.
- R5: On a latch event, every channel's holding register takes that channel's capture value from before the clock edge. This includes a channel whose edge falls in the same cycle; that channel's capture register still takes the new timer value.
- R6: On a latch event, each pulse accumulator's count goes into `pacc_hold[j*PAW +: PAW]` and the accumulator clears to 0. If the accumulator's channel has an edge in that same cycle, the accumulator restarts at 1.
- R7: In latch mode, an edge without a latch event leaves every holding register unchanged.
- R8: Accumulator j (0 ≤ j < NPA) counts the edges of channel j. Its count is `pacc_val[j*PAW +: PAW]`, it rises by one per edge and it stays at 255 once it reaches it.
- R9: While `rst_n` is low, all capture, holding, accumulator and accumulator-holding registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | TW | Current main timer count |
| edge_evt | input | NCH | Qualified edge, one bit per channel |
| latch_mode | input | 1 | 0 queue mode, 1 latch mode |
| mod_zero | input | 1 | Modulus down-counter reached zero |
| mod_zero_wr | input | 1 | Software wrote zero to the modulus count |
| cap_val | output | NCH*TW | Capture registers, channel i at [i*TW +: TW] |
| hold_val | output | NCH*TW | Holding registers, channel i at [i*TW +: TW] |
| pacc_val | output | NPA*PAW | Pulse accumulators, j at [j*PAW +: PAW] |
| pacc_hold | output | NPA*PAW | Accumulator holding registers |

## Verification
The assertions assume the inputs are stable, single-cycle-qualified levels sampled at each rising edge. They also assume any edge bit may be high in any cycle, together with a latch request. The bench holds to this by driving all inputs on the falling edge, one cycle per step.

The stimulus sweeps every edge pattern of the eight channels in queue mode. It also mixes in latch events in latch mode, including events that coincide with edges, and a run long enough to saturate the accumulators.

// File: rtl/capbank_pkg.sv
package capbank_pkg;

  typedef enum logic {
    MODE_QUEUE = 1'b0,
    MODE_LATCH = 1'b1
  } cap_mode_e;

  // A snapshot request counts only in latch mode.
  function automatic logic snap_request(cap_mode_e mode, logic at_zero, logic zero_wr);
    return (mode == MODE_LATCH) && (at_zero || zero_wr);
  endfunction

  // Queue shifting happens only in queue mode.
  function automatic logic queue_active(cap_mode_e mode);
    return mode == MODE_QUEUE;
  endfunction

endpackage

// File: rtl/capbank_latch_ctl.sv
module capbank_latch_ctl
  import capbank_pkg::*;
(
  input  logic mode_i,
  input  logic at_zero_i,
  input  logic zero_wr_i,
  output logic snap_o,
  output logic queue_o
);

  cap_mode_e mode_q;

  always_comb begin
    mode_q  = cap_mode_e'(mode_i);
    snap_o  = snap_request(mode_q, at_zero_i, zero_wr_i);
    queue_o = queue_active(mode_q);
  end

endmodule

// File: rtl/capbank_chan.sv
module capbank_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic          snap_i,
  input  logic          queue_i,
  input  logic [TW-1:0] timer_i,
  output logic [TW-1:0] cap_o,
  output logic [TW-1:0] hold_o
);

  logic          push_hold;
  logic [TW-1:0] cap_q;
  logic [TW-1:0] hold_q;

  // The holding register loads on a snapshot, or on a capture in queue mode.
  assign push_hold = snap_i || (queue_i && edge_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (edge_i) begin
      cap_q <= timer_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (push_hold) begin
      hold_q <= cap_q;
    end
  end

  assign cap_o  = cap_q;
  assign hold_o = hold_q;

endmodule

// File: rtl/capbank_pacc.sv
module capbank_pacc #(
  parameter int PAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           edge_i,
  input  logic           snap_i,
  output logic [PAW-1:0] cnt_o,
  output logic [PAW-1:0] hold_o
);

  localparam logic [PAW-1:0] CNT_MAX = '1;

  function automatic logic [PAW-1:0] sat_step(logic [PAW-1:0] v, logic inc);
    if (!inc || v == CNT_MAX) return v;
    return v + 1'b1;
  endfunction

  logic [PAW-1:0] cnt_q;
  logic [PAW-1:0] hold_q;
  logic [PAW-1:0] cnt_nx;

  always_comb begin
    if (snap_i) cnt_nx = sat_step('0, edge_i);
    else        cnt_nx = sat_step(cnt_q, edge_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (snap_i) hold_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;

endmodule

// File: rtl/capt_hold_bank.sv
module capt_hold_bank #(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int NPA = 4,
  parameter int PAW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TW-1:0]      timer_val,
  input  logic [NCH-1:0]     edge_evt,
  input  logic               latch_mode,
  input  logic               mod_zero,
  input  logic               mod_zero_wr,
  output logic [NCH*TW-1:0]  cap_val,
  output logic [NCH*TW-1:0]  hold_val,
  output logic [NPA*PAW-1:0] pacc_val,
  output logic [NPA*PAW-1:0] pacc_hold
);

  // Named internal events, visible to the bound checker.
  logic latch_evt;
  logic queue_en;

  capbank_latch_ctl u_ctl (
    .mode_i    (latch_mode),
    .at_zero_i (mod_zero),
    .zero_wr_i (mod_zero_wr),
    .snap_o    (latch_evt),
    .queue_o   (queue_en)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    capbank_chan #(.TW(TW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .edge_i  (edge_evt[gi]),
      .snap_i  (latch_evt),
      .queue_i (queue_en),
      .timer_i (timer_val),
      .cap_o   (cap_val[gi*TW +: TW]),
      .hold_o  (hold_val[gi*TW +: TW])
    );
  end

  for (genvar gj = 0; gj < NPA; gj++) begin : g_pacc
    capbank_pacc #(.PAW(PAW)) u_pacc (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (edge_evt[gj]),
      .snap_i (latch_evt),
      .cnt_o  (pacc_val[gj*PAW +: PAW]),
      .hold_o (pacc_hold[gj*PAW +: PAW])
    );
  end

endmodule

// File: rtl/capt_hold_bank_chk.sv
module capt_hold_bank_chk #(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int NPA = 4,
  parameter int PAW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [TW-1:0]      timer_val,
  input logic [NCH-1:0]     edge_evt,
  input logic               latch_mode,
  input logic               latch_evt,
  input logic [NCH*TW-1:0]  cap_val,
  input logic [NCH*TW-1:0]  hold_val,
  input logic [NPA*PAW-1:0] pacc_val,
  input logic [NPA*PAW-1:0] pacc_hold
);

  localparam logic [PAW-1:0] PMAX = '1;

  // R9: reset clears every register
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (cap_val == '0 && hold_val == '0 && pacc_val == '0 && pacc_hold == '0));

  // R4: no latch event in queue mode
  a_r4_no_latch_in_queue: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_mode |-> !latch_evt);

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    // R2
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[gi] |=> cap_val[gi*TW +: TW] == $past(timer_val));
    // R3
    a_r3_queue_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_mode && edge_evt[gi]) |=> hold_val[gi*TW +: TW] == $past(cap_val[gi*TW +: TW]));
    // R5
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      latch_evt |=> hold_val[gi*TW +: TW] == $past(cap_val[gi*TW +: TW]));
    // R7
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && !latch_evt) |=> $stable(hold_val[gi*TW +: TW]));
  end

  for (genvar gj = 0; gj < NPA; gj++) begin : g_pa
    // R6
    a_r6_pacc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_evt && !edge_evt[gj]) |=> pacc_val[gj*PAW +: PAW] == '0);
    a_r6_pacc_snap: assert property (@(posedge clk) disable iff (!rst_n)
      latch_evt |=> pacc_hold[gj*PAW +: PAW] == $past(pacc_val[gj*PAW +: PAW]));
    // R8
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (pacc_val[gj*PAW +: PAW] == PMAX && !latch_evt) |=> pacc_val[gj*PAW +: PAW] == PMAX);
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_evt[gj] && !latch_evt) |=> $stable(pacc_val[gj*PAW +: PAW]));
  end

endmodule

bind capt_hold_bank capt_hold_bank_chk #(
  .NCH(NCH), .TW(TW), .NPA(NPA), .PAW(PAW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .timer_val  (timer_val),
  .edge_evt   (edge_evt),
  .latch_mode (latch_mode),
  .latch_evt  (latch_evt),
  .cap_val    (cap_val),
  .hold_val   (hold_val),
  .pacc_val   (pacc_val),
  .pacc_hold  (pacc_hold)
);

// File: tb/test_capt_hold_bank.sv
`timescale 1ns/1ps
module test_capt_hold_bank;

  localparam int NCH = 8;
  localparam int TW  = 16;
  localparam int NPA = 4;
  localparam int PAW = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [TW-1:0]      timer_val = '0;
  logic [NCH-1:0]     edge_evt = '0;
  logic               latch_mode = 1'b0;
  logic               mod_zero = 1'b0;
  logic               mod_zero_wr = 1'b0;
  logic [NCH*TW-1:0]  cap_val;
  logic [NCH*TW-1:0]  hold_val;
  logic [NPA*PAW-1:0] pacc_val;
  logic [NPA*PAW-1:0] pacc_hold;

  capt_hold_bank #(.NCH(NCH), .TW(TW), .NPA(NPA), .PAW(PAW)) i_capt_hold_bank (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .edge_evt(edge_evt),
    .latch_mode(latch_mode), .mod_zero(mod_zero), .mod_zero_wr(mod_zero_wr),
    .cap_val(cap_val), .hold_val(hold_val), .pacc_val(pacc_val), .pacc_hold(pacc_hold)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_cap [NCH];
  int m_hold[NCH];
  int m_pa  [NPA];
  int m_ph  [NPA];

  function automatic logic [NCH*TW-1:0] pack_ch(int a[NCH]);
    logic [NCH*TW-1:0] v = '0;
    for (int i = 0; i < NCH; i++) v[i*TW +: TW] = a[i][TW-1:0];
    return v;
  endfunction

  function automatic logic [NPA*PAW-1:0] pack_pa(int a[NPA]);
    logic [NPA*PAW-1:0] v = '0;
    for (int i = 0; i < NPA; i++) v[i*PAW +: PAW] = a[i][PAW-1:0];
    return v;
  endfunction

  task automatic compare(string tag);
    logic [NCH*TW-1:0]  ec = pack_ch(m_cap);
    logic [NCH*TW-1:0]  eh = pack_ch(m_hold);
    logic [NPA*PAW-1:0] ep = pack_pa(m_pa);
    logic [NPA*PAW-1:0] eq = pack_pa(m_ph);
    checks++;
    if (cap_val !== ec || hold_val !== eh || pacc_val !== ep || pacc_hold !== eq) begin
      errors++;
      $display("FAIL %s: cap=%h hold=%h pacc=%h phold=%h expected cap=%h hold=%h pacc=%h phold=%h",
               tag, cap_val, hold_val, pacc_val, pacc_hold, ec, eh, ep, eq);
    end
  endtask

  // Model update from the requirements: one clock edge with the given inputs.
  task automatic model(logic [NCH-1:0] e, logic md, logic mz, logic wr, int tv);
    bit snap = md && (mz || wr);
    for (int i = 0; i < NCH; i++) begin
      if (snap || (!md && e[i])) m_hold[i] = m_cap[i];
      if (e[i]) m_cap[i] = tv % 65536;
    end
    for (int j = 0; j < NPA; j++) begin
      if (snap) begin
        m_ph[j] = m_pa[j];
        m_pa[j] = e[j] ? 1 : 0;
      end else if (e[j] && m_pa[j] < 255) begin
        m_pa[j] = m_pa[j] + 1;
      end
    end
  endtask

  // Called at a falling edge: drive, clock, then compare at the next falling edge.
  task automatic step(logic [NCH-1:0] e, logic md, logic mz, logic wr, int tv, string tag);
    edge_evt = e; latch_mode = md; mod_zero = mz; mod_zero_wr = wr; timer_val = tv[TW-1:0];
    @(posedge clk);
    model(e, md, mz, wr, tv);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_model();
    for (int i = 0; i < NCH; i++) begin m_cap[i] = 0; m_hold[i] = 0; end
    for (int j = 0; j < NPA; j++) begin m_pa[j] = 0; m_ph[j] = 0; end
  endtask

  initial begin
    clear_model();
    // R9: reset dominates, even with edges present
    edge_evt = '1; timer_val = 16'h1234;
    repeat (3) @(negedge clk);
    compare("R9 reset");
    edge_evt = '0;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9 after release");

    // R2 R3: all edge patterns in queue mode (R1 mode 0)
    for (int p = 0; p < 256; p++)
      step(p[NCH-1:0], 1'b0, 1'b0, 1'b0, p * 257 + 3, "R1 R2 R3 queue sweep");

    // R4: latch requests in queue mode have no effect
    step('0, 1'b0, 1'b1, 1'b0, 11, "R4 mod_zero ignored");
    step('0, 1'b0, 1'b0, 1'b1, 12, "R4 zero write ignored");
    step('0, 1'b0, 1'b1, 1'b1, 13, "R4 both ignored");

    // R5 R6 R7: latch mode with mixed events
    for (int k = 0; k < 300; k++) begin
      logic [NCH-1:0] e = NCH'($urandom);
      bit lat = (k % 7 == 3);
      bit mz = lat && (k % 2 == 0);
      bit wr = lat && (k % 2 == 1);
      step(e, 1'b1, mz, wr, 1000 + k * 37, lat ? "R4 R5 R6 latch" : "R7 R8 latch idle");
    end
    step('1, 1'b1, 1'b1, 1'b0, 16'hBEEF, "R5 R6 coincident edge");

    // R8: saturation
    for (int k = 0; k < 270; k++)
      step(NCH'(4'hF), 1'b1, 1'b0, 1'b0, k, "R8 saturate");
    step('0, 1'b1, 1'b0, 1'b1, 5, "R6 R8 snapshot saturated");

    // R1: back to queue mode
    for (int k = 0; k < 20; k++)
      step(NCH'($urandom), 1'b0, k[0], k[1], 3000 + k, "R1 R3 R4 queue again");

    // R9: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    clear_model();
    @(negedge clk);
    compare("R9 mid-run reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule